// File: doc/BRIEF.md
# Parallel Self-Clocked LED Lane Serializer

This block drives up to eight single-wire LED data lines in lockstep. Each line uses a self-clocked return-to-zero code. Every bit period is split into three phases of programmable length. All active lines rise together when a period starts. A line whose bit is 0 falls once the first phase ends. A line whose bit is 1 stays high through the second phase. Every line is low for the whole third phase. One shared waveform therefore carries a different bit on each line.

A frame begins with a start pulse that carries the number of LEDs. The block then pulls one input word for each byte slot, three slots per LED, over a valid/ready handshake. Each word holds one byte per lane. The block turns the eight lane bytes into bit planes: in every period it sends the same bit position on all lanes, most significant bit first. It can add zero bits after each byte. When the frame ends it holds the lines low for a minimum idle gap and stays busy until the gap has passed. If no word is offered when a byte slot is due, the frame ends early with an error flag.

Top module: `multilane_led_serializer`

## Requirements
- R1: While reset is held and after it is released, lane_out is 0 and busy, in_ready and underrun are 0 until a start is accepted.
- R2: Each bit period lasts T1+T2+T3 cycles. During its first T1 cycles, every lane below N_LANES is high.
- R3: In cycles T1 to T1+T2-1 of a period, a lane is high only if its current bit is 1. In the last T3 cycles, every lane is low.
- R4: lane_out bits at positions N_LANES and above are always 0, whatever in_data holds.
- R5: Lane l takes its byte from in_data[8l+7:8l]. The byte is sent most significant bit first, and in any period all lanes send the same bit position.
- R6: in_ready is high for exactly one cycle per byte slot. The first slot is the cycle after the start is accepted. Each later slot is the last cycle of the previous byte, so bytes follow each other with no gap. A frame has 3*led_count slots.
- R7: After the eight data bits of each byte, XTRA_BITS further periods are sent with bit value 0.
- R8: After the last period of a frame, the lanes stay low and busy stays high for IDLE_CYC cycles. Then busy falls. A start is only taken while busy is low, and a start while busy has no effect.
- R9: If in_valid is low in a byte-slot cycle, underrun rises in the next cycle and the lanes stay low. The idle gap of R8 follows. underrun stays high until the next accepted start clears it.
- R10: A start with led_count 0 sends no periods and raises no in_ready. It holds busy for IDLE_CYC cycles starting in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a frame when busy is low |
| led_count | input | CNT_W | Number of LEDs in the frame |
| in_valid | input | 1 | Input word offered |
| in_data | input | 64 | Eight lane bytes; lane l in bits 8l+7..8l |
| in_ready | output | 1 | Byte slot due; word taken if in_valid |
| lane_out | output | 8 | Serial data lines |
| busy | output | 1 | Frame or idle gap in progress |
| underrun | output | 1 | Sticky flag: last frame ended on missing data |

## Verification
A phase counter that is off by one shifts a falling edge, and the shift shows on lane_out in the first period of the frame. A wrong bit index makes some lane carry the wrong byte bit, and this shows within one byte slot. A byte count or slot timing that is off moves the in_ready pulse or the start of the gap, so it shows by the end of the frame. The bench predicts all four outputs on every cycle of every frame, so each of these faults is caught at the cycle where it first appears at the ports.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;
    typedef enum logic [1:0] {
        PH_HIGH = 2'd0,
        PH_DATA = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_SEND = 2'd2,
        ST_GAP  = 2'd3
    } state_e;

    localparam int LANES_HW = 8;
endpackage

// File: rtl/led_bit_timer.sv
module led_bit_timer
    import led_ser_pkg::*;
#(
    parameter int T1    = 25,
    parameter int T2    = 35,
    parameter int T3    = 40,
    parameter int BITS  = 8,
    parameter int BIT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    output phase_e           phase,
    output logic [BIT_W-1:0] bit_idx,
    output logic             slot_end
);
    localparam int TOTAL = T1 + T2 + T3;
    localparam int CYC_W = $clog2(TOTAL);
    localparam logic [CYC_W-1:0] EDGE_A = CYC_W'(T1);
    localparam logic [CYC_W-1:0] EDGE_B = CYC_W'(T1 + T2);
    localparam logic [CYC_W-1:0] LAST_C = CYC_W'(TOTAL - 1);
    localparam logic [BIT_W-1:0] LAST_B = BIT_W'(BITS - 1);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic [BIT_W-1:0] bidx;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (restart) begin
            d.cyc  = '0;
            d.bidx = '0;
        end else if (run) begin
            if (q.cyc == LAST_C) begin
                d.cyc  = '0;
                d.bidx = (q.bidx == LAST_B) ? '0 : q.bidx + 1'b1;
            end else begin
                d.cyc = q.cyc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        if (q.cyc < EDGE_A)      phase = PH_HIGH;
        else if (q.cyc < EDGE_B) phase = PH_DATA;
        else                     phase = PH_LOW;
    end

    assign bit_idx  = q.bidx;
    assign slot_end = run && (q.cyc == LAST_C) && (q.bidx == LAST_B);
endmodule

// File: rtl/led_plane_mux.sv
module led_plane_mux
    import led_ser_pkg::*;
#(
    parameter int N_LANES = 8,
    parameter int BIT_W   = 3
) (
    input  logic [8*LANES_HW-1:0] word,
    input  logic [BIT_W-1:0]      bit_idx,
    input  phase_e                phase,
    input  logic                  enable,
    output logic [LANES_HW-1:0]   lanes
);
    localparam logic [LANES_HW-1:0] LANE_MASK = LANES_HW'((1 << N_LANES) - 1);

    logic [LANES_HW-1:0] plane;
    logic                data_bit;

    assign data_bit = (bit_idx < BIT_W'(8));

    for (genvar l = 0; l < LANES_HW; l++) begin : g_lane
        logic [7:0] lane_byte;
        assign lane_byte = word[8*l +: 8];
        assign plane[l]  = data_bit && lane_byte[3'd7 - bit_idx[2:0]];
    end

    always_comb begin
        lanes = '0;
        if (enable) begin
            unique case (phase)
                PH_HIGH: lanes = LANE_MASK;
                PH_DATA: lanes = LANE_MASK & plane;
                default: lanes = '0;
            endcase
        end
    end
endmodule

// File: rtl/multilane_led_serializer.sv
module multilane_led_serializer
    import led_ser_pkg::*;
#(
    parameter int N_LANES   = 8,
    parameter int T1        = 25,
    parameter int T2        = 35,
    parameter int T3        = 40,
    parameter int XTRA_BITS = 0,
    parameter int IDLE_CYC  = 5000,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] led_count,
    input  logic             in_valid,
    input  logic [63:0]      in_data,
    output logic             in_ready,
    output logic [7:0]       lane_out,
    output logic             busy,
    output logic             underrun
);
    localparam int BITS  = 8 + XTRA_BITS;
    localparam int BIT_W = $clog2(BITS + 1);
    localparam int BL_W  = CNT_W + 2;
    localparam int GAP_W = $clog2(IDLE_CYC + 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(IDLE_CYC - 1);

    typedef struct packed {
        state_e            state;
        logic [63:0]       word;
        logic [BL_W-1:0]   bytes_left;
        logic [GAP_W-1:0]  gap_cnt;
        logic              underrun;
    } ctl_t;

    ctl_t q, d;

    phase_e           phase;
    logic [BIT_W-1:0] bit_idx;
    logic             slot_end;
    logic             restart;
    logic             slot_due;
    logic [BL_W-1:0]  total_bytes;

    assign total_bytes = ({2'b00, led_count} << 1) + {2'b00, led_count};
    assign slot_due = (q.state == ST_LOAD) ||
                      ((q.state == ST_SEND) && slot_end && (q.bytes_left != '0));

    always_comb begin
        d       = q;
        restart = 1'b0;
        if (slot_due) begin
            if (in_valid) begin
                d.word       = in_data;
                d.bytes_left = q.bytes_left - 1'b1;
                d.state      = ST_SEND;
                restart      = 1'b1;
            end else begin
                d.underrun = 1'b1;
                d.state    = ST_GAP;
                d.gap_cnt  = '0;
            end
        end else begin
            unique case (q.state)
                ST_IDLE: begin
                    if (start) begin
                        d.underrun   = 1'b0;
                        d.bytes_left = total_bytes;
                        d.gap_cnt    = '0;
                        d.state      = (led_count == '0) ? ST_GAP : ST_LOAD;
                    end
                end
                ST_SEND: begin
                    if (slot_end) begin
                        d.state   = ST_GAP;
                        d.gap_cnt = '0;
                    end
                end
                ST_GAP: begin
                    if (q.gap_cnt == GAP_LAST) d.state   = ST_IDLE;
                    else                       d.gap_cnt = q.gap_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    led_bit_timer #(
        .T1(T1), .T2(T2), .T3(T3), .BITS(BITS), .BIT_W(BIT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .run      (q.state == ST_SEND),
        .phase    (phase),
        .bit_idx  (bit_idx),
        .slot_end (slot_end)
    );

    led_plane_mux #(
        .N_LANES(N_LANES), .BIT_W(BIT_W)
    ) u_mux (
        .word    (q.word),
        .bit_idx (bit_idx),
        .phase   (phase),
        .enable  (q.state == ST_SEND),
        .lanes   (lane_out)
    );

    assign in_ready = slot_due;
    assign busy     = (q.state != ST_IDLE);
    assign underrun = q.underrun;
endmodule

// File: rtl/led_ser_checker.sv
module led_ser_checker #(
    parameter int N_LANES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic [7:0] lane_out,
    input logic       busy,
    input logic       underrun
);
    localparam logic [7:0] LANE_MASK = 8'((1 << N_LANES) - 1);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lane_out == 8'h00)); // R8

    AST_UPPER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_out & ~LANE_MASK) == 8'h00); // R4

    AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy); // R6

    AST_JOINT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(lane_out) == 8'h00 && lane_out != 8'h00) |-> (lane_out == LANE_MASK)); // R2

    AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(lane_out) != 8'h00) |-> ((lane_out & ~$past(lane_out)) == 8'h00)); // R3

    AST_UNDERRUN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (lane_out == 8'h00 && !in_ready)); // R9
endmodule

bind multilane_led_serializer led_ser_checker #(.N_LANES(N_LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .lane_out (lane_out),
    .busy     (busy),
    .underrun (underrun)
);

// File: tb/multilane_led_serializer_test.sv
`timescale 1ns/1ps
module multilane_led_serializer_test;
    localparam int NL = 5, P1 = 2, P2 = 3, P3 = 2, XB = 1, IDLE = 10, CW = 8;
    localparam int TOT = P1 + P2 + P3;
    localparam int BP  = (8 + XB) * TOT;
    localparam logic [7:0] MASK = 8'((1 << NL) - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] led_count = '0;
    logic          in_valid = 1'b0;
    logic [63:0]   in_data = '0;
    logic          in_ready;
    logic [7:0]    lane_out;
    logic          busy;
    logic          underrun;

    int n_checks = 0;
    int n_errors = 0;
    int tick = 0;

    always #2 clk = ~clk;

    multilane_led_serializer #(
        .N_LANES(NL), .T1(P1), .T2(P2), .T3(P3),
        .XTRA_BITS(XB), .IDLE_CYC(IDLE), .CNT_W(CW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .led_count(led_count),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .lane_out(lane_out), .busy(busy), .underrun(underrun)
    );

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    always @(posedge clk) begin
        tick <= tick + 1;
        if (tick == 150000) begin
            n_checks = n_checks + 1;
            n_errors = n_errors + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp, int n);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_errors = n_errors + 1;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, n, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_byte(int b, int l, int seed);
        if (seed == 1) return 8'hFF;
        if (seed == 2) return 8'h00;
        return 8'(b * 37 + l * 29 + seed * 11 + 5);
    endfunction

    function automatic logic [63:0] pat(int b, int seed);
        logic [63:0] w;
        for (int l = 0; l < 8; l++) w[8*l +: 8] = pat_byte(b, l, seed);
        return w;
    endfunction

    // One frame: count LEDs, underrun on slot u (u >= 3*count: none).
    task automatic frame(int count, int u, int seed, bit mid_start);
        int nb, sent, end_send, last_n, nxt, lastslot;
        bit prev_rdy;
        nb   = 3 * count;
        sent = (u < nb) ? u : nb;
        end_send = (nb == 0) ? 1 : 2 + sent * BP;
        lastslot = (u < nb) ? u : nb - 1;
        last_n = end_send + IDLE + 1;
        nxt = 0;
        prev_rdy = 1'b0;
        @(negedge clk);
        start = 1'b1;
        led_count = CW'(count);
        in_data = pat(0, seed);
        in_valid = (u != 0);
        for (int n = 1; n <= last_n; n++) begin
            logic [7:0] e_lane;
            logic e_busy, e_rdy, e_und;
            string tag;
            @(negedge clk);
            if (prev_rdy) nxt++;
            in_data  = pat(nxt, seed);
            in_valid = (nxt != u);
            start = (mid_start && n == 5);
            led_count = mid_start ? CW'(7) : CW'(count);
            e_lane = 8'h00;
            tag = (nb == 0) ? "R10" : ((u < nb) ? "R9" : "R8");
            if (n >= 2 && n < end_send) begin
                int k, b, j, c;
                logic [7:0] bits;
                k = n - 2; b = k / BP; j = (k % BP) / TOT; c = k % TOT;
                for (int l = 0; l < 8; l++)
                    bits[l] = (j < 8) ? pat_byte(b, l, seed)[7 - j] : 1'b0;
                if (c < P1)           e_lane = MASK;
                else if (c < P1 + P2) e_lane = MASK & bits;
                if (c < P1)      tag = "R2";
                else if (j >= 8) tag = "R7";
                else             tag = "R3 R5";
            end
            if (((lane_out ^ e_lane) & ~MASK) != 8'h00) tag = "R4";
            e_busy = (n < end_send + IDLE);
            e_rdy  = (nb > 0) && ((n - 1) % BP == 0) && ((n - 1) / BP <= lastslot);
            e_und  = (u < nb) && (n >= end_send);
            check(tag, lane_out, e_lane, n);
            check((nb == 0) ? "R10 busy" : "R8 busy", {7'b0, busy}, {7'b0, e_busy}, n);
            check((nb == 0) ? "R10 in_ready" : "R6 in_ready", {7'b0, in_ready}, {7'b0, e_rdy}, n);
            check("R9 underrun", {7'b0, underrun}, {7'b0, e_und}, n);
            prev_rdy = in_ready;
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 lanes", lane_out, 8'h00, 0);
        check("R1 busy", {7'b0, busy}, 8'h00, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 ready", {7'b0, in_ready}, 8'h00, 0);
        check("R1 underrun", {7'b0, underrun}, 8'h00, 0);
        check("R1 busy", {7'b0, busy}, 8'h00, 0);
        frame(0, 99, 0, 1'b0);   // R10
        frame(1, 99, 1, 1'b0);   // all ones, R2 R3 R4
        frame(1, 99, 2, 1'b0);   // all zeros, R3 R7
        frame(2, 99, 3, 1'b0);   // R5 R6
        frame(3, 99, 4, 1'b1);   // start while busy ignored, R8
        frame(2, 0, 5, 1'b0);    // underrun on first slot, R9
        frame(2, 3, 6, 1'b0);    // underrun mid frame, R9
        frame(1, 2, 7, 1'b0);    // underrun on last slot, R9
        frame(1, 99, 8, 1'b0);   // underrun cleared by new start, R9
        report();
    end
endmodule